// File: doc/BRIEF.md
# Masked Halfword Register Bank for a Command Ring Controller

This block is the host-facing register file of a command ring controller. Software reaches it through a 16-bit access port. Each 32-bit ring address is split into a low and a high halfword, and there are eight of them: ring start, ring limit, the upper and lower fill thresholds, fill distance, producer pointer, consumer pointer and stop address. Every halfword write passes through a fixed mask. The low half keeps only bits 15:5, so each address stays on a 32-byte boundary. The high half keeps only the bits that the physical address space can reach. The masked values drive the controller directly through a flat output bus.

The bank also holds a full-width token register and a control register. The control register drives six enable bits into the controller. Several registers can only be read:

- four bounding-box registers with fixed values;
- a row of metric registers that return constants;
- a performance-select register that reads as zero;
- a status register that samples the status bits the controller supplies.

A write to any read-only or unmapped address changes nothing. A read returns its data, registered, in the cycle after the request.

Top module: `cmd_regbank`

## Requirements
- R1: After reset, every address halfword, the control register and the token read as 0. The bounding-box registers at 0x04, 0x05, 0x06 and 0x07 read 0, 0, 640 and 480 (left, top, right, bottom).
- R2: A write to the low half of address register i (address 0x10+2i, i = 0..7) stores the write data AND 0xFFE0. That half reads back, and appears on areg_q[32i+15:32i], with the same value.
- R3: A write to the high half of address register i (address 0x11+2i) stores the write data AND 0x03FF, or AND 0x1FFF when WIDE_HI=1. That half reads back, and appears on areg_q[32i+31:32i+16], with the same value.
- R4: The high half of the consumer pointer (register 6, address 0x1D) is masked on write like the other high halves. Later reads return the masked value, not the value written.
- R5: Writes to the bounding-box addresses 0x04 to 0x07 are ignored, and those addresses keep their reset values.
- R6: The metric addresses 0x20 to 0x2D read 0. Address 0x2E reads the clocks-per-vertex constant, 4 by default. Writes to any of them are ignored.
- R7: Address 0x00 is read-only and returns the sampled status bits: bit0 overflow, bit1 underflow, bit2 read idle, bit3 command idle, bit4 breakpoint, all other bits 0.
- R8: Address 0x01 is the control register. Its bits are bit0 read enable, bit1 breakpoint enable, bit2 overflow interrupt enable, bit3 underflow interrupt enable, bit4 link enable and bit5 breakpoint interrupt enable. ctl_q takes the new value in the cycle right after the write, and reads return it with bits 15:6 as 0.
- R9: Address 0x02 is a token register: all 16 bits are written and read back unchanged.
- R10: Address 0x03, performance select, ignores writes and always reads 0.
- R11: A read request (req_valid=1, req_write=0) raises rsp_valid with the read data in the next cycle. rsp_valid is 0 in the cycle after any other request cycle.
- R12: Addresses 0x08 to 0x0F and 0x2F to 0x3F read 0, and a write to any of them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Halfword register address |
| req_wdata | input | 16 | Write data |
| stat_in | input | STAT_W | Live status bits from the controller |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Registered read data |
| ctl_q | output | CTL_W | Control enables to the controller |
| areg_q | output | NUM_AREG*32 | Masked address registers, register i at bits 32i+31:32i |

## Verification
The bench sweeps all 64 addresses. It reads every address after reset, then writes and reads the whole map back with several data patterns: all ones, two alternating patterns, one mixed pattern and all zeros. The all-ones and alternating patterns show which bits each mask lets through, and how the low and high masks differ. Mixing the address into the data shows whether a write lands in the wrong halfword or register. Read-only and unmapped addresses must keep their values across every write sweep.

A narrow and a wide instance receive the same accesses, which tells the two high-half mask variants apart. A sweep over all 32 status input values checks the position of each status bit.

// File: rtl/cmd_regbank_pkg.sv
package cmd_regbank_pkg;

   localparam logic [15:0] LO_MASK        = 16'hFFE0;
   localparam logic [15:0] HI_MASK_NARROW = 16'h03FF;
   localparam logic [15:0] HI_MASK_WIDE   = 16'h1FFF;

   localparam int A_STATUS  = 0;
   localparam int A_CTRL    = 1;
   localparam int A_TOKEN   = 2;
   localparam int A_PSEL    = 3;
   localparam int A_BBOX    = 4;
   localparam int N_BBOX    = 4;
   localparam int A_AREG    = 16;
   localparam int A_METRIC  = 32;

   typedef enum logic [2:0] {
      K_NONE,
      K_STAT,
      K_CTRL,
      K_TOKEN,
      K_PSEL,
      K_BBOX,
      K_AREG,
      K_METRIC
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic [3:0] idx;
      logic       hi;
   } dec_t;

endpackage

// File: rtl/cmd_regbank_decode.sv
module cmd_regbank_decode
   import cmd_regbank_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int NUM_AREG   = 8,
   parameter int METRIC_NUM = 15
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam int AREG_END   = A_AREG + 2 * NUM_AREG;
   localparam int METRIC_END = A_METRIC + METRIC_NUM;

   int unsigned a;

   always_comb begin
      a        = 32'(addr);
      dec.kind = K_NONE;
      dec.idx  = '0;
      dec.hi   = 1'b0;
      if (a == A_STATUS) begin
         dec.kind = K_STAT;
      end else if (a == A_CTRL) begin
         dec.kind = K_CTRL;
      end else if (a == A_TOKEN) begin
         dec.kind = K_TOKEN;
      end else if (a == A_PSEL) begin
         dec.kind = K_PSEL;
      end else if (a >= A_BBOX && a < A_BBOX + N_BBOX) begin
         dec.kind = K_BBOX;
         dec.idx  = 4'(a - A_BBOX);
      end else if (a >= A_AREG && a < AREG_END) begin
         dec.kind = K_AREG;
         dec.idx  = 4'((a - A_AREG) >> 1);
         dec.hi   = addr[0];
      end else if (a >= A_METRIC && a < METRIC_END) begin
         dec.kind = K_METRIC;
         dec.idx  = 4'(a - A_METRIC);
      end
   end

endmodule

// File: rtl/cmd_regbank_addrreg.sv
module cmd_regbank_addrreg #(
   parameter logic [15:0] LO_KEEP = 16'hFFE0,
   parameter logic [15:0] HI_KEEP = 16'h03FF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we_lo,
   input  logic        we_hi,
   input  logic [15:0] wdata,
   output logic [31:0] q
);

   logic [15:0] lo_r;
   logic [15:0] hi_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_r <= '0;
         hi_r <= '0;
      end else begin
         if (we_lo) lo_r <= wdata & LO_KEEP;
         if (we_hi) hi_r <= wdata & HI_KEEP;
      end
   end

   assign q = {hi_r, lo_r};

endmodule

// File: rtl/cmd_regbank_rdmux.sv
module cmd_regbank_rdmux
   import cmd_regbank_pkg::*;
#(
   parameter int          NUM_AREG   = 8,
   parameter int          CTL_W      = 6,
   parameter int          STAT_W     = 5,
   parameter int          METRIC_NUM = 15,
   parameter logic [15:0] CPV        = 16'd4,
   parameter logic [15:0] BBOX_L     = 16'd0,
   parameter logic [15:0] BBOX_T     = 16'd0,
   parameter logic [15:0] BBOX_R     = 16'd640,
   parameter logic [15:0] BBOX_B     = 16'd480
) (
   input  dec_t                   dec,
   input  logic [NUM_AREG*32-1:0] areg,
   input  logic [CTL_W-1:0]       ctl,
   input  logic [15:0]            tok,
   input  logic [STAT_W-1:0]      stat,
   output logic [15:0]            rdata
);

   localparam int CPV_IDX = METRIC_NUM - 1;

   logic [15:0] bbox_val [N_BBOX];

   assign bbox_val[0] = BBOX_L;
   assign bbox_val[1] = BBOX_T;
   assign bbox_val[2] = BBOX_R;
   assign bbox_val[3] = BBOX_B;

   always_comb begin
      rdata = '0;
      unique case (dec.kind)
         K_STAT:   rdata = 16'(stat);
         K_CTRL:   rdata = 16'(ctl);
         K_TOKEN:  rdata = tok;
         K_BBOX:   rdata = bbox_val[dec.idx[1:0]];
         K_AREG:   rdata = areg[int'(dec.idx) * 32 + (dec.hi ? 16 : 0) +: 16];
         K_METRIC: rdata = (int'(dec.idx) == CPV_IDX) ? CPV : 16'd0;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/cmd_regbank.sv
module cmd_regbank
   import cmd_regbank_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          NUM_AREG = 8,
   parameter int          CTL_W    = 6,
   parameter int          STAT_W   = 5,
   parameter bit          WIDE_HI  = 1'b0,
   parameter logic [15:0] CPV      = 16'd4,
   parameter logic [15:0] BBOX_R   = 16'd640,
   parameter logic [15:0] BBOX_B   = 16'd480
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [15:0]            req_wdata,
   input  logic [STAT_W-1:0]      stat_in,
   output logic                   rsp_valid,
   output logic [15:0]            rsp_rdata,
   output logic [CTL_W-1:0]       ctl_q,
   output logic [NUM_AREG*32-1:0] areg_q
);

   localparam int METRIC_NUM = 15;

   if (ADDR_W < 6) begin : g_chk_addr
      $error("cmd_regbank: ADDR_W must be at least 6");
   end
   if (NUM_AREG < 1 || NUM_AREG > 8) begin : g_chk_areg
      $error("cmd_regbank: NUM_AREG must be 1..8");
   end
   if (CTL_W < 1 || CTL_W > 16 || STAT_W < 1 || STAT_W > 16) begin : g_chk_w
      $error("cmd_regbank: CTL_W and STAT_W must be 1..16");
   end

   dec_t        dec;
   logic        wr_en;
   logic        rd_en;
   logic [15:0] tok_r;
   logic [15:0] rdata_nxt;

   assign wr_en = req_valid &&  req_write;
   assign rd_en = req_valid && !req_write;

   cmd_regbank_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_AREG  (NUM_AREG),
      .METRIC_NUM(METRIC_NUM)
   ) i_decode (
      .addr(req_addr),
      .dec (dec)
   );

   for (genvar i = 0; i < NUM_AREG; i++) begin : g_areg
      logic sel;
      assign sel = wr_en && dec.kind == K_AREG && int'(dec.idx) == i;
      if (WIDE_HI) begin : g_wide
         cmd_regbank_addrreg #(.LO_KEEP(LO_MASK), .HI_KEEP(HI_MASK_WIDE)) i_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we_lo(sel && !dec.hi),
            .we_hi(sel &&  dec.hi),
            .wdata(req_wdata),
            .q    (areg_q[i*32 +: 32])
         );
      end else begin : g_narrow
         cmd_regbank_addrreg #(.LO_KEEP(LO_MASK), .HI_KEEP(HI_MASK_NARROW)) i_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we_lo(sel && !dec.hi),
            .we_hi(sel &&  dec.hi),
            .wdata(req_wdata),
            .q    (areg_q[i*32 +: 32])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         tok_r <= '0;
      end else if (wr_en) begin
         if (dec.kind == K_CTRL)  ctl_q <= req_wdata[CTL_W-1:0];
         if (dec.kind == K_TOKEN) tok_r <= req_wdata;
      end
   end

   cmd_regbank_rdmux #(
      .NUM_AREG  (NUM_AREG),
      .CTL_W     (CTL_W),
      .STAT_W    (STAT_W),
      .METRIC_NUM(METRIC_NUM),
      .CPV       (CPV),
      .BBOX_L    (16'd0),
      .BBOX_T    (16'd0),
      .BBOX_R    (BBOX_R),
      .BBOX_B    (BBOX_B)
   ) i_rdmux (
      .dec  (dec),
      .areg (areg_q),
      .ctl  (ctl_q),
      .tok  (tok_r),
      .stat (stat_in),
      .rdata(rdata_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_en;
         rsp_rdata <= rd_en ? rdata_nxt : 16'd0;
      end
   end

endmodule

// File: rtl/cmd_regbank_chk.sv
module cmd_regbank_chk #(
   parameter int          ADDR_W   = 6,
   parameter int          NUM_AREG = 8,
   parameter int          CTL_W    = 6,
   parameter int          STAT_W   = 5,
   parameter bit          WIDE_HI  = 1'b0,
   parameter logic [15:0] CPV      = 16'd4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_write,
   input logic [ADDR_W-1:0]      req_addr,
   input logic [15:0]            req_wdata,
   input logic [STAT_W-1:0]      stat_in,
   input logic                   rsp_valid,
   input logic [15:0]            rsp_rdata,
   input logic [CTL_W-1:0]       ctl_q,
   input logic [NUM_AREG*32-1:0] areg_q
);

   localparam logic [15:0] HM = WIDE_HI ? 16'h1FFF : 16'h03FF;

   logic              p_rd, p_wr;
   logic [ADDR_W-1:0] p_addr;
   logic [15:0]       p_data;
   logic [STAT_W-1:0] p_stat;
   int unsigned       pa, ca;
   int                p_idx;
   logic              p_is_areg, p_is_metric, p_unmapped, c_is_bbox;
   logic [15:0]       half_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_rd   <= 1'b0;
         p_wr   <= 1'b0;
         p_addr <= '0;
         p_data <= '0;
         p_stat <= '0;
      end else begin
         p_rd   <= req_valid && !req_write;
         p_wr   <= req_valid &&  req_write;
         p_addr <= req_addr;
         p_data <= req_wdata;
         p_stat <= stat_in;
      end
   end

   always_comb begin
      pa          = 32'(p_addr);
      ca          = 32'(req_addr);
      p_is_areg   = pa >= 16 && pa < 16 + 2 * NUM_AREG;
      p_is_metric = pa >= 32 && pa <= 46;
      p_unmapped  = (pa >= 8 && pa < 16) || (pa >= 16 + 2 * NUM_AREG && pa < 32) || pa >= 47;
      c_is_bbox   = ca >= 4 && ca <= 7;
      p_idx       = p_is_areg ? int'((pa - 16) >> 1) : 0;
      half_view   = areg_q[p_idx * 32 + (p_addr[0] ? 16 : 0) +: 16];
   end

   assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   assert_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);
   assert_lo_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && p_is_areg && !p_addr[0]) |-> (half_view == (p_data & 16'hFFE0)));
   assert_hi_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && p_is_areg && p_addr[0]) |-> (half_view == (p_data & HM)));
   assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rd && pa == 0) |-> (rsp_rdata == 16'(p_stat)));
   assert_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && pa == 1) |-> (ctl_q == p_data[CTL_W-1:0]));
   assert_metric_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rd && p_is_metric) |-> (rsp_rdata == ((pa == 46) ? CPV : 16'd0)));
   assert_psel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rd && pa == 3) |-> (rsp_rdata == 16'd0));
   assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rd && p_unmapped) |-> (rsp_rdata == 16'd0));
   assert_bbox_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && c_is_bbox) |=> ($stable(areg_q) && $stable(ctl_q)));

endmodule

bind cmd_regbank cmd_regbank_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_AREG(NUM_AREG),
   .CTL_W   (CTL_W),
   .STAT_W  (STAT_W),
   .WIDE_HI (WIDE_HI),
   .CPV     (CPV)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_addr (req_addr),
   .req_wdata(req_wdata),
   .stat_in  (stat_in),
   .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata),
   .ctl_q    (ctl_q),
   .areg_q   (areg_q)
);

// File: tb/test_cmd_regbank.sv
module test_cmd_regbank;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [5:0]   req_addr = '0;
   logic [15:0]  req_wdata = '0;
   logic [4:0]   stat_in = '0;
   logic         rsp_valid_n, rsp_valid_w;
   logic [15:0]  rsp_rdata_n, rsp_rdata_w;
   logic [5:0]   ctl_n, ctl_w;
   logic [255:0] areg_n, areg_w;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] m_areg_n [8];
   logic [31:0] m_areg_w [8];
   logic [5:0]  m_ctl;
   logic [15:0] m_tok;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_regbank i_cmd_regbank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .stat_in(stat_in),
      .rsp_valid(rsp_valid_n), .rsp_rdata(rsp_rdata_n), .ctl_q(ctl_n), .areg_q(areg_n)
   );

   cmd_regbank #(.WIDE_HI(1'b1)) i_cmd_regbank_wide (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .stat_in(stat_in),
      .rsp_valid(rsp_valid_w), .rsp_rdata(rsp_rdata_w), .ctl_q(ctl_w), .areg_q(areg_w)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag(input int a);
      if (a == 0) return "R7";
      if (a == 1) return "R8";
      if (a == 2) return "R9";
      if (a == 3) return "R10";
      if (a >= 4 && a <= 7) return "R5";
      if (a >= 16 && a < 32) begin
         if (a % 2 == 0) return "R2";
         if (a == 29) return "R4";
         return "R3";
      end
      if (a >= 32 && a <= 46) return "R6";
      return "R12";
   endfunction

   function automatic logic [15:0] expect_rd(input bit wide, input int a);
      logic [31:0] r;
      if (a == 0) return 16'(stat_in);
      if (a == 1) return 16'(m_ctl);
      if (a == 2) return m_tok;
      if (a == 6) return 16'd640;
      if (a == 7) return 16'd480;
      if (a >= 16 && a < 32) begin
         r = wide ? m_areg_w[(a - 16) / 2] : m_areg_n[(a - 16) / 2];
         return (a % 2 == 1) ? r[31:16] : r[15:0];
      end
      if (a == 46) return 16'd4;
      return 16'd0;
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      if (a == 1) m_ctl = d[5:0];
      if (a == 2) m_tok = d;
      if (a >= 16 && a < 32) begin
         if (a % 2 == 0) begin
            m_areg_n[(a - 16) / 2][15:0] = d & 16'hFFE0;
            m_areg_w[(a - 16) / 2][15:0] = d & 16'hFFE0;
         end else begin
            m_areg_n[(a - 16) / 2][31:16] = d & 16'h03FF;
            m_areg_w[(a - 16) / 2][31:16] = d & 16'h1FFF;
         end
      end
   endtask

   task automatic rd_check(input int a, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " narrow"}, 32'(rsp_rdata_n), 32'(expect_rd(1'b0, a)));
      check({req, " wide"},   32'(rsp_rdata_w), 32'(expect_rd(1'b1, a)));
   endtask

   task automatic check_outputs(input string req);
      for (int i = 0; i < 8; i++) begin
         check({req, " areg narrow"}, areg_n[i*32 +: 32], m_areg_n[i]);
         check({req, " areg wide"},   areg_w[i*32 +: 32], m_areg_w[i]);
      end
      check({req, " ctl"}, 32'(ctl_n), 32'(m_ctl));
   endtask

   initial begin
      logic [15:0] pats [5];
      pats[0] = 16'hFFFF; pats[1] = 16'hAAAA; pats[2] = 16'h5555;
      pats[3] = 16'h9C3B; pats[4] = 16'h0000;
      for (int i = 0; i < 8; i++) begin
         m_areg_n[i] = '0;
         m_areg_w[i] = '0;
      end
      m_ctl = '0;
      m_tok = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents over the whole map
      check_outputs("R1");
      for (int a = 0; a < 64; a++) rd_check(a, "R1");

      // R11: response timing
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd6;
      @(negedge clk);
      req_valid = 1'b0;
      check("R11 valid after read", 32'(rsp_valid_n), 32'd1);
      check("R11 data after read", 32'(rsp_rdata_n), 32'd640);
      @(negedge clk);
      check("R11 idle after no request", 32'(rsp_valid_n), 32'd0);
      wr(2, 16'h1111);
      check("R11 idle after write", 32'(rsp_valid_n), 32'd0);

      // R8: control takes effect in the cycle after the write
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd1; req_wdata = 16'hFFEA;
      @(posedge clk);
      #1 check("R8 ctl next cycle", 32'(ctl_n), 32'h2A);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      m_ctl = 6'h2A;

      // full-map write/read sweeps with several patterns
      foreach (pats[p]) begin
         for (int a = 0; a < 64; a++) wr(a, pats[p] ^ 16'(a * 16'h0101));
         check_outputs(p == 0 ? "R2" : "R3");
         for (int a = 0; a < 64; a++) rd_check(a, tag(a));
      end

      // R7: every status input value
      for (int v = 0; v < 32; v++) begin
         stat_in = 5'(v);
         rd_check(0, "R7");
      end
      stat_in = '0;

      // R12: unmapped writes leave every register unchanged
      wr(2, 16'hBEEF);
      for (int a = 8; a < 16; a++) wr(a, 16'hFFFF);
      for (int a = 47; a < 64; a++) wr(a, 16'hFFFF);
      check_outputs("R12");
      rd_check(2, "R12 token kept");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule